// File: doc/BRIEF.md
# Vertex output semantic mapper

This block sits between a vertex shader's output stage and the rasterizer setup logic. The shader delivers its output attributes one per beat, each beat carrying four 24-bit float components (x, y, z, w). For each attribute a configuration word gives a 5-bit destination code per component. The code selects one of 24 semantic slots, such as position, quaternion, color, texture coordinates or view vector. The block scatters every component into its slot and sends the complete slot set to the rasterizer as one output vertex.

A code of 31 marks an unused component, and its write is dropped. Codes 24 to 30 are also dropped, and they set a sticky error flag. The four color slots (8 to 11) are stored as the absolute value of the incoming component, clamped so that the value never exceeds 1.0. Slots that no attribute writes come out as zero. A valid/ready pair carries the output vertex. While a vertex waits to be taken, the block holds its input ready low.

Software sets the routing through a small write-only register port. Addresses 0 to 6 hold the map words for attributes 0 to 6. Address 7 holds the count of active attributes.

Top module: `vsem_mapper`

## Requirements
- R1: After reset, out_valid and err_flag are 0, in_ready is 1 and out_slots is all zero.
- R2: A write to cfg_addr 7 stores cfg_wdata[2:0] as the active attribute count N, and the upper bits are ignored. A beat whose attribute index is N or more is accepted but changes no slot.
- R3: A map word written to cfg_addr a (0..6) holds the codes for components x, y, z and w in bits [4:0], [12:8], [20:16] and [28:24]. The other bits are ignored. Component c of a beat is in_data[24c+23:24c], and slot s is out_slots[24s+23:24s]. A code 0..23 writes that component to that slot.
- R4: Code 31 drops the component. No slot changes and err_flag stays 0.
- R5: Codes 24..30 drop the component and set err_flag, which stays 1 until reset.
- R6: If two components target the same slot, the last one written wins. Attributes are applied in ascending index order, and within one attribute w beats z, z beats y and y beats x.
- R7: Each value written to slots 8..11 has its sign bit (bit 23) cleared. If the remaining magnitude is 24'h3F0000 (1.0) or more, the slot receives 24'h3F0000.
- R8: A slot not written during a vertex reads zero. All slots return to zero in the cycle after an output handshake.
- R9: out_valid rises in the cycle after the beat with in_last is accepted. in_ready is low while out_valid is high. out_slots holds steady until out_ready is seen.
- R10: The beat with in_last ends the vertex. Attribute indices count from 0 at the first beat of each vertex, and beats after the seventh are treated as index 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address: 0..6 map words, 7 attribute count |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input attribute beat valid |
| in_ready | output | 1 | Block can accept an attribute beat |
| in_last | input | 1 | Beat is the last of the vertex |
| in_data | input | 96 | Four 24-bit components, x in the low bits |
| out_valid | output | 1 | Output vertex valid |
| out_ready | input | 1 | Consumer takes the output vertex |
| out_slots | output | 576 | 24 semantic slots of 24 bits, slot 0 in the low bits |
| err_flag | output | 1 | Sticky flag for a reserved code (24..30) |

## Verification
A wrong attribute index or a stale map lookup sends components to the wrong slot. This shows as a mismatched slot in the very next output vertex. A slot file that is not cleared on the handshake leaks values into the following vertex, which shows as non-zero slots that the new routing never wrote. A saturation fault shows as a color slot with its sign bit set or a value above 1.0. An error flag that fails to latch, or drops after it has latched, shows on err_flag at the vertex that used the reserved code or at any later vertex.

// File: rtl/vsem_pkg.sv
package vsem_pkg;
  localparam int VSEM_FW         = 24;
  localparam int VSEM_NCOMP      = 4;
  localparam int VSEM_NSLOT      = 24;
  localparam int VSEM_CODE_W     = 5;
  localparam int VSEM_NATTR      = 7;
  localparam int VSEM_CNT_W      = 3;
  localparam int VSEM_COLOR_BASE = 8;
  localparam int VSEM_NCOLOR     = 4;
  localparam logic [VSEM_FW-1:0] VSEM_ONE = 24'h3F0000;
endpackage

// File: rtl/vsem_cfg.sv
module vsem_cfg #(
  parameter int NATTR  = vsem_pkg::VSEM_NATTR,
  parameter int NCOMP  = vsem_pkg::VSEM_NCOMP,
  parameter int CODE_W = vsem_pkg::VSEM_CODE_W,
  parameter int CNT_W  = vsem_pkg::VSEM_CNT_W,
  parameter int AW     = 3,
  parameter int DW     = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [DW-1:0]           cfg_wdata,
  input  logic [CNT_W-1:0]        rd_idx,
  output logic [NCOMP*CODE_W-1:0] rd_codes,
  output logic [CNT_W-1:0]        attr_count
);
  localparam int MW = NCOMP * CODE_W;
  localparam int BYTE_W = DW / NCOMP;
  localparam logic [AW-1:0] CNT_ADDR = AW'(NATTR);

  logic [MW-1:0] map_q [NATTR];
  logic [MW-1:0] wr_codes;
  logic [CNT_W-1:0] count_q;

  for (genvar c = 0; c < NCOMP; c++) begin : g_pack
    assign wr_codes[c*CODE_W +: CODE_W] = cfg_wdata[c*BYTE_W +: CODE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      for (int a = 0; a < NATTR; a++) map_q[a] <= '1;
    end else if (cfg_we) begin
      if (cfg_addr == CNT_ADDR) count_q <= cfg_wdata[CNT_W-1:0];
      else if (cfg_addr < CNT_ADDR) map_q[cfg_addr] <= wr_codes;
    end
  end

  assign rd_codes   = (rd_idx < CNT_W'(NATTR)) ? map_q[rd_idx] : '1;
  assign attr_count = count_q;
endmodule

// File: rtl/vsem_route.sv
module vsem_route #(
  parameter int NCOMP      = vsem_pkg::VSEM_NCOMP,
  parameter int NSLOT      = vsem_pkg::VSEM_NSLOT,
  parameter int FW         = vsem_pkg::VSEM_FW,
  parameter int CODE_W     = vsem_pkg::VSEM_CODE_W,
  parameter int COLOR_BASE = vsem_pkg::VSEM_COLOR_BASE,
  parameter int NCOLOR     = vsem_pkg::VSEM_NCOLOR,
  parameter logic [FW-1:0] ONE_ENC = vsem_pkg::VSEM_ONE
) (
  input  logic                    active,
  input  logic [NCOMP*CODE_W-1:0] codes,
  input  logic [NCOMP*FW-1:0]     data,
  output logic [NSLOT-1:0]        slot_we,
  output logic [NSLOT*FW-1:0]     slot_wd,
  output logic                    bad_code
);
  localparam logic [CODE_W-1:0] DROP = '1;

  function automatic logic [FW-1:0] sat_color(input logic [FW-1:0] v);
    logic [FW-1:0] mag;
    mag = {1'b0, v[FW-2:0]};
    return (mag >= ONE_ENC) ? ONE_ENC : mag;
  endfunction

  always_comb begin
    slot_we  = '0;
    slot_wd  = '0;
    bad_code = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      for (int c = 0; c < NCOMP; c++) begin
        if (active && codes[c*CODE_W +: CODE_W] == CODE_W'(s)) begin
          slot_we[s] = 1'b1;
          slot_wd[s*FW +: FW] = data[c*FW +: FW];
        end
      end
      if (s >= COLOR_BASE && s < COLOR_BASE + NCOLOR)
        slot_wd[s*FW +: FW] = sat_color(slot_wd[s*FW +: FW]);
    end
    for (int c = 0; c < NCOMP; c++) begin
      if (active && codes[c*CODE_W +: CODE_W] >= CODE_W'(NSLOT) &&
          codes[c*CODE_W +: CODE_W] != DROP)
        bad_code = 1'b1;
    end
  end
endmodule

// File: rtl/vsem_slots.sv
module vsem_slots #(
  parameter int NSLOT = vsem_pkg::VSEM_NSLOT,
  parameter int FW    = vsem_pkg::VSEM_FW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic [NSLOT-1:0]    we,
  input  logic [NSLOT*FW-1:0] wd,
  output logic [NSLOT*FW-1:0] q
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) q[s*FW +: FW] <= '0;
      else if (we[s]) q[s*FW +: FW] <= wd[s*FW +: FW];
    end
  end
endmodule

// File: rtl/vsem_mapper.sv
module vsem_mapper #(
  parameter int FW         = vsem_pkg::VSEM_FW,
  parameter int NCOMP      = vsem_pkg::VSEM_NCOMP,
  parameter int NSLOT      = vsem_pkg::VSEM_NSLOT,
  parameter int CODE_W     = vsem_pkg::VSEM_CODE_W,
  parameter int NATTR      = vsem_pkg::VSEM_NATTR,
  parameter int CNT_W      = vsem_pkg::VSEM_CNT_W,
  parameter int COLOR_BASE = vsem_pkg::VSEM_COLOR_BASE,
  parameter int NCOLOR     = vsem_pkg::VSEM_NCOLOR,
  parameter logic [FW-1:0] ONE_ENC = vsem_pkg::VSEM_ONE,
  parameter int AW         = 3,
  parameter int DW         = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [DW-1:0]       cfg_wdata,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_last,
  input  logic [NCOMP*FW-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [NSLOT*FW-1:0] out_slots,
  output logic                err_flag
);
  logic [CNT_W-1:0]        attr_idx;
  logic [CNT_W-1:0]        attr_count;
  logic [NCOMP*CODE_W-1:0] cur_codes;
  logic [NSLOT-1:0]        slot_we;
  logic [NSLOT*FW-1:0]     slot_wd;
  logic                    bad_code;
  logic                    ov_q;
  logic                    err_q;
  logic                    accept;
  logic                    take;
  logic                    beat_active;

  assign in_ready    = !ov_q;
  assign accept      = in_valid && in_ready;
  assign take        = ov_q && out_ready;
  assign beat_active = accept && (attr_idx < attr_count);

  vsem_cfg #(
    .NATTR(NATTR), .NCOMP(NCOMP), .CODE_W(CODE_W), .CNT_W(CNT_W),
    .AW(AW), .DW(DW)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_idx(attr_idx), .rd_codes(cur_codes),
    .attr_count(attr_count)
  );

  vsem_route #(
    .NCOMP(NCOMP), .NSLOT(NSLOT), .FW(FW), .CODE_W(CODE_W),
    .COLOR_BASE(COLOR_BASE), .NCOLOR(NCOLOR), .ONE_ENC(ONE_ENC)
  ) u_route (
    .active(beat_active), .codes(cur_codes), .data(in_data),
    .slot_we(slot_we), .slot_wd(slot_wd), .bad_code(bad_code)
  );

  vsem_slots #(.NSLOT(NSLOT), .FW(FW)) u_slots (
    .clk(clk), .rst(rst), .clr(take), .we(slot_we), .wd(slot_wd),
    .q(out_slots)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_idx <= '0;
      ov_q     <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (accept) begin
        if (in_last) begin
          attr_idx <= '0;
          ov_q     <= 1'b1;
        end else if (attr_idx != '1) begin
          attr_idx <= attr_idx + 1'b1;
        end
      end else if (take) begin
        ov_q <= 1'b0;
      end
      if (bad_code) err_q <= 1'b1;
    end
  end

  assign out_valid = ov_q;
  assign err_flag  = err_q;
endmodule

// File: rtl/vsem_mapper_chk.sv
module vsem_mapper_chk #(
  parameter int FW         = 24,
  parameter int NSLOT      = 24,
  parameter int COLOR_BASE = 8,
  parameter int NCOLOR     = 4,
  parameter logic [FW-1:0] ONE_ENC = 24'h3F0000
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic                in_last,
  input logic                out_valid,
  input logic                out_ready,
  input logic [NSLOT*FW-1:0] out_slots,
  input logic                err_flag
);
  a_r9_valid_after_last: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> out_valid);

  a_r9_valid_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready && in_last));

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slots)));

  a_r8_clear_after_take: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid && out_slots == '0));

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  for (genvar k = 0; k < NCOLOR; k++) begin : g_col
    a_r7_color_range: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (!out_slots[(COLOR_BASE+k)*FW + FW-1] &&
                     out_slots[(COLOR_BASE+k)*FW +: FW] <= ONE_ENC));
  end
endmodule

bind vsem_mapper vsem_mapper_chk #(
  .FW(FW), .NSLOT(NSLOT), .COLOR_BASE(COLOR_BASE), .NCOLOR(NCOLOR),
  .ONE_ENC(ONE_ENC)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_slots(out_slots), .err_flag(err_flag)
);

// File: tb/vsem_mapper_bench.sv
module vsem_mapper_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         cfg_we;
  logic [2:0]   cfg_addr;
  logic [31:0]  cfg_wdata;
  logic         in_valid;
  logic         in_ready;
  logic         in_last;
  logic [95:0]  in_data;
  logic         out_valid;
  logic         out_ready;
  logic [575:0] out_slots;
  logic         err_flag;

  int checks = 0;
  int errors = 0;

  logic [31:0] bmap [7];
  int          bcount;
  logic [23:0] exp_s [24];
  logic        exp_err;
  logic [95:0] bdata [8];

  always #5 clk = ~clk;

  vsem_mapper u_vsem_mapper (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_slots(out_slots), .err_flag(err_flag)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] mw(input int x, input int y, input int z, input int w);
    return (32'(w) << 24) | (32'(z) << 16) | (32'(y) << 8) | 32'(x);
  endfunction

  function automatic logic [23:0] bsat(input int code, input logic [23:0] v);
    logic [23:0] m;
    if (code < 8 || code > 11) return v;
    m = v & 24'h7FFFFF;
    return (m >= 24'h3F0000) ? 24'h3F0000 : m;
  endfunction

  function automatic logic [23:0] mkval(input int n);
    return 24'((n * 24'h9E3B) ^ (n << 13) ^ 24'h51A7);
  endfunction

  task automatic cfg(input int addr, input logic [31:0] data);
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr < 7) bmap[addr] = data;
    else bcount = int'(data & 32'h7);
  endtask

  task automatic model_beat(input int idx, input logic [95:0] d);
    if (idx < bcount) begin
      for (int c = 0; c < 4; c++) begin
        int code;
        code = int'((bmap[idx] >> (8 * c)) & 32'h1F);
        if (code < 24) exp_s[code] = bsat(code, d[c*24 +: 24]);
        else if (code != 31) exp_err = 1'b1;
      end
    end
  endtask

  task automatic run_vertex(input int nbeats, input string tag);
    for (int s = 0; s < 24; s++) exp_s[s] = '0;
    for (int b = 0; b < nbeats; b++) begin
      chk(in_ready == 1'b1, "R9", 32'(in_ready), 1);
      in_valid = 1'b1; in_data = bdata[b]; in_last = (b == nbeats - 1);
      model_beat((b < 7) ? b : 7, bdata[b]);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
    end
    chk(out_valid == 1'b1, "R9", 32'(out_valid), 1);
    chk(in_ready == 1'b0, "R9", 32'(in_ready), 0);
    for (int s = 0; s < 24; s++)
      chk(out_slots[s*24 +: 24] == exp_s[s], tag, 32'(out_slots[s*24 +: 24]), 32'(exp_s[s]));
    chk(err_flag == exp_err, "R5", 32'(err_flag), 32'(exp_err));
    @(negedge clk);
    chk(out_valid == 1'b1, "R9", 32'(out_valid), 1);
    for (int s = 0; s < 24; s++)
      chk(out_slots[s*24 +: 24] == exp_s[s], "R9", 32'(out_slots[s*24 +: 24]), 32'(exp_s[s]));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R8", 32'(out_valid), 0);
    chk(out_slots == '0, "R8", 32'(out_slots[31:0]), 0);
    chk(in_ready == 1'b1, "R10", 32'(in_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0; in_last = 1'b0; in_data = '0; out_ready = 1'b0;
    exp_err = 1'b0; bcount = 0;
    for (int a = 0; a < 7; a++) bmap[a] = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", 32'(in_ready), 1);
    chk(err_flag == 1'b0, "R1", 32'(err_flag), 0);
    chk(out_slots == '0, "R1", 32'(out_slots[31:0]), 0);

    // R3 identity routing with junk in bits 7:5, R7 color saturation
    for (int a = 0; a < 6; a++) cfg(a, mw(4*a, 4*a+1, 4*a+2, 4*a+3) | 32'hE0E0E0E0);
    cfg(7, 6);
    for (int a = 0; a < 6; a++)
      for (int c = 0; c < 4; c++) bdata[a][c*24 +: 24] = mkval(a*4 + c);
    bdata[2] = {24'h3EFFFF, 24'hBF0000, 24'h400000, 24'hBE0000};
    run_vertex(6, "R3");
    chk(out_slots == '0, "R7", 32'(out_slots[31:0]), 0);

    // R6 ordering: slot1 gets attr0.z then attr1.x
    cfg(0, mw(0, 1, 1, 5)); cfg(1, mw(1, 31, 31, 31)); cfg(7, 2);
    bdata[0] = {24'h000444, 24'h000333, 24'h000222, 24'h000111};
    bdata[1] = {24'h000888, 24'h000777, 24'h000666, 24'h000555};
    run_vertex(2, "R6");
    cfg(7, 1);
    run_vertex(1, "R6");

    // R4 unused code: only slot 2 written, no error
    cfg(0, mw(31, 31, 31, 2)); cfg(7, 1);
    bdata[0] = {24'h0ABCDE, 24'h111111, 24'h222222, 24'h333333};
    run_vertex(1, "R4");
    chk(err_flag == 1'b0, "R4", 32'(err_flag), 0);

    // R2 count masking: 0x39 gives 1 active attribute
    cfg(0, mw(3, 31, 31, 31)); cfg(1, mw(4, 5, 6, 7)); cfg(2, mw(3, 3, 3, 3));
    cfg(7, 32'h39);
    for (int b = 0; b < 3; b++)
      for (int c = 0; c < 4; c++) bdata[b][c*24 +: 24] = mkval(100 + b*4 + c);
    run_vertex(3, "R2");

    // R10 count zero and beats past the seventh
    cfg(7, 0);
    run_vertex(1, "R10");
    for (int a = 0; a < 7; a++) cfg(a, mw(12 + a, 31, 31, 31));
    cfg(7, 7);
    for (int b = 0; b < 8; b++)
      for (int c = 0; c < 4; c++) bdata[b][c*24 +: 24] = mkval(200 + b*4 + c);
    run_vertex(8, "R10");

    // R5 reserved code sets sticky flag
    cfg(0, mw(25, 0, 31, 31)); cfg(7, 1);
    bdata[0] = {24'h0, 24'h0, 24'h012345, 24'h0FFFFF};
    run_vertex(1, "R5");
    cfg(0, mw(0, 1, 2, 3));
    run_vertex(1, "R5");
    chk(err_flag == 1'b1, "R5", 32'(err_flag), 1);

    // R3/R4/R5 sweep of every code on component x
    for (int code = 0; code < 32; code++) begin
      cfg(0, mw(code, 31, 31, 31)); cfg(7, 1);
      bdata[0] = {24'h0, 24'h0, 24'h0, mkval(300 + code)};
      run_vertex(1, "R3");
    end

    // R7 color sweep around 1.0
    cfg(0, mw(8, 9, 10, 11)); cfg(7, 1);
    for (int i = 0; i < 48; i++) begin
      for (int c = 0; c < 4; c++) begin
        int n;
        n = i*4 + c;
        bdata[0][c*24 +: 24] = 24'(((n & 1) << 23) | ((60 + (n % 7)) << 16) |
                                   ((n * 24'h1357) & 24'hFFFF & ((n % 5 == 0) ? 0 : 24'hFFFF)));
      end
      run_vertex(1, "R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule